// File: doc/BRIEF.md
# Compare-Connect Audio Stream Matcher

After a read disturbance interrupts recording, this block finds the point in the re-read audio stream where recording can resume without a gap or a repeat. While it is idle it keeps the six most recent accepted 16-bit samples, which are three left/right pairs of confirmed audio. When a start command arrives, it matches the incoming interleaved stream against that reference. It raises a one-cycle connect pulse at the point where the re-read data lines up with the reference.

Three start modes exist. The strict mode needs all three pairs to agree. The relaxed mode needs any two of the three. The direct mode makes no comparison and connects after a fixed number of words. A mask option drops the four least significant bits of every sample from the comparison, so small differences in those bits do not block a connect. The first start after reset waits out a preparation interval before it searches. Every later start begins searching at the next left-channel sample.

Top module: `cc_connect_matcher`

## Requirements
- R1: While reset is asserted and after it is released, `busy` and `connect_done` are 0.
- R2: A command with `cmd_mode` 2'b11 (three pairs), 2'b10 (two of three) or 2'b01 (direct) makes `busy` 1 from the next cycle. A command with `cmd_mode` 2'b00 issued while busy sets `busy` to 0 on the next cycle and produces no `connect_done` pulse.
- R3: A 2'b00 command issued while idle has no effect. `busy` stays 0, no pulse occurs, and the stored reference is unchanged.
- R4: While idle, each sample strobe shifts the sample into the reference. The reference holds the last six idle samples, oldest first: left, right, left, right, left, right.
- R5: The first start after reset ignores all samples for 960 clock cycles. After that it waits for a left-channel sample (`smp_right`=0) before the search begins.
- R6: A later start skips the preparation interval. It ignores any right-channel samples and begins at the next left-channel sample. Reissuing a start while busy restarts the search.
- R7: In three-pair mode, `connect_done` pulses in the cycle after the strobe of the right-channel sample for which the last six searched samples equal the reference. `busy` clears in that same cycle.
- R8: In two-of-three mode, the connect happens at such a right-channel strobe when at least two of the three sample pairs equal their reference pairs.
- R9: In direct mode, the connect happens at the third searched word, with no comparison made.
- R10: While `cmp12`=1, bits [3:0] of each sample are excluded from the comparison. The option is applied at each comparison, so it can be turned on in the middle of a search.
- R11: `connect_done` lasts exactly one cycle and occurs only while a sequence was active.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_mode | input | 2 | 11 three-pair, 10 two-of-three, 01 direct, 00 stop |
| cmp12 | input | 1 | Exclude the low four bits from the comparison |
| smp_valid | input | 1 | Sample strobe |
| smp_right | input | 1 | Channel tag: 0 left, 1 right |
| smp_data | input | 16 | Audio sample |
| busy | output | 1 | A start, preparation or search sequence is active |
| connect_done | output | 1 | One-cycle pulse when a connect is declared |

## Verification
The assertions assume the following about the inputs. The sample tags alternate left and right within a search. A command and a sample strobe never fall in the same cycle. `cmp12` changes only between strobes. The bench drives every input at the falling edge and spaces each strobe by two cycles. It builds every searched sequence as left, right pairs, and it changes the mask only in the gap between two samples, so the stimulus keeps within these assumptions.

// File: rtl/cc_pkg.sv
`timescale 1ns/1ps
package cc_pkg;
  typedef enum logic [1:0] {
    MODE_STOP   = 2'b00,
    MODE_DIRECT = 2'b01,
    MODE_TWO    = 2'b10,
    MODE_THREE  = 2'b11
  } cc_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_PREP,
    ST_WAIT_L,
    ST_SEARCH
  } cc_state_e;
endpackage

// File: rtl/cc_sample_shift.sv
`timescale 1ns/1ps
module cc_sample_shift #(
  parameter int W     = 16,
  parameter int DEPTH = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               shift_en,
  input  logic [W-1:0]       din,
  output logic [DEPTH*W-1:0] dout,
  output logic [DEPTH*W-1:0] dout_next
);
  logic [DEPTH*W-1:0] mem_q;

  // newest entry lands at the top slot, oldest sits in slot 0
  always_comb begin
    dout_next = {din, mem_q[DEPTH*W-1:W]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mem_q <= '0;
    else if (shift_en) mem_q <= dout_next;
  end

  assign dout = mem_q;

  AST_SHIFT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |=> $stable(dout)); // R4
endmodule

// File: rtl/cc_pair_compare.sv
`timescale 1ns/1ps
module cc_pair_compare #(
  parameter int W        = 16,
  parameter int PAIRS    = 3,
  parameter int LOW_BITS = 4,
  localparam int CW      = $clog2(PAIRS + 1)
) (
  input  logic [2*PAIRS*W-1:0] ref_flat,
  input  logic [2*PAIRS*W-1:0] win_flat,
  input  logic                 mask_en,
  output logic [CW-1:0]        match_count,
  output logic                 all_match
);
  logic [W-1:0]     keep;
  logic [PAIRS-1:0] pair_eq;

  assign keep = mask_en ? {{(W-LOW_BITS){1'b1}}, {LOW_BITS{1'b0}}} : {W{1'b1}};

  for (genvar p = 0; p < PAIRS; p++) begin : g_pair
    logic [W-1:0] diff_l, diff_r;
    assign diff_l = (ref_flat[(2*p)*W +: W]   ^ win_flat[(2*p)*W +: W])   & keep;
    assign diff_r = (ref_flat[(2*p+1)*W +: W] ^ win_flat[(2*p+1)*W +: W]) & keep;
    assign pair_eq[p] = (diff_l == '0) && (diff_r == '0);
  end

  always_comb begin
    match_count = '0;
    for (int p = 0; p < PAIRS; p++) match_count = match_count + CW'(pair_eq[p]);
  end

  assign all_match = &pair_eq;
endmodule

// File: rtl/cc_seq_ctrl.sv
`timescale 1ns/1ps
module cc_seq_ctrl
  import cc_pkg::*;
#(
  parameter int PAIRS        = 3,
  parameter int PREP_CYCLES  = 960,
  parameter int DIRECT_WORDS = 3,
  localparam int CW          = $clog2(PAIRS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  logic [1:0]    cmd_mode,
  input  logic          smp_valid,
  input  logic          smp_right,
  input  logic [CW-1:0] match_count,
  input  logic          all_match,
  output logic          ref_shift,
  output logic          win_shift,
  output logic          busy,
  output logic          done
);
  localparam int WORDS    = 2 * PAIRS;
  localparam int WW       = $clog2(WORDS + 1);
  localparam int PW       = $clog2(PREP_CYCLES + 1);
  localparam int TWO_NEED = PAIRS - 1;

  cc_state_e state_q, state_d;
  cc_mode_e  mode_q, mode_d, cmd_m;
  logic [PW-1:0] prep_q, prep_d;
  logic [WW-1:0] cnt_q, cnt_d, cnt_inc;
  logic primed_q, primed_d, done_q, done_d, pass;

  assign cmd_m   = cc_mode_e'(cmd_mode);
  assign cnt_inc = (cnt_q >= WW'(WORDS)) ? WW'(WORDS) : cnt_q + 1'b1;
  assign pass    = (mode_q == MODE_THREE) ? all_match : (match_count >= CW'(TWO_NEED));

  always_comb begin
    state_d = state_q; mode_d = mode_q; prep_d = prep_q; cnt_d = cnt_q;
    primed_d = primed_q; done_d = 1'b0; ref_shift = 1'b0; win_shift = 1'b0;
    if (cmd_valid) begin
      if (cmd_m != MODE_STOP) begin
        mode_d   = cmd_m;
        cnt_d    = '0;
        prep_d   = PW'(PREP_CYCLES - 1);
        state_d  = primed_q ? ST_WAIT_L : ST_PREP;
        primed_d = 1'b1;
      end else if (state_q != ST_IDLE) begin
        state_d = ST_IDLE;
      end
    end else begin
      case (state_q)
        ST_IDLE: ref_shift = smp_valid;
        ST_PREP: begin
          if (prep_q == '0) state_d = ST_WAIT_L;
          else prep_d = prep_q - 1'b1;
        end
        ST_WAIT_L: begin
          if (smp_valid && !smp_right) begin
            win_shift = 1'b1;
            cnt_d     = WW'(1);
            state_d   = ST_SEARCH;
          end
        end
        default: begin
          if (smp_valid) begin
            win_shift = 1'b1;
            cnt_d     = cnt_inc;
            if (mode_q == MODE_DIRECT) begin
              if (cnt_inc >= WW'(DIRECT_WORDS)) begin
                done_d = 1'b1; state_d = ST_IDLE;
              end
            end else if (smp_right && cnt_inc == WW'(WORDS) && pass) begin
              done_d = 1'b1; state_d = ST_IDLE;
            end
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE; mode_q <= MODE_STOP; prep_q <= '0;
      cnt_q <= '0; primed_q <= 1'b0; done_q <= 1'b0;
    end else begin
      state_q <= state_d; mode_q <= mode_d; prep_q <= prep_d;
      cnt_q <= cnt_d; primed_q <= primed_d; done_q <= done_d;
    end
  end

  assign busy = (state_q != ST_IDLE);
  assign done = done_q;

  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_mode != 2'b00) |=> busy); // R2
  AST_STOP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_mode == 2'b00) |=> (!busy && !done)); // R3
  AST_PREP_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_PREP) |-> (prep_q < PW'(PREP_CYCLES))); // R5
  AST_RESTART_NO_PREP: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_mode != 2'b00 && primed_q) |=> (state_q == ST_WAIT_L)); // R6
  AST_FULL_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    all_match |-> (match_count == CW'(PAIRS))); // R7
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R11
  AST_DONE_FROM_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(busy) && !busy)); // R11
endmodule

// File: rtl/cc_connect_matcher.sv
`timescale 1ns/1ps
module cc_connect_matcher #(
  parameter int SAMPLE_W     = 16,
  parameter int PAIRS        = 3,
  parameter int LOW_BITS     = 4,
  parameter int PREP_CYCLES  = 960,
  parameter int DIRECT_WORDS = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cmd_valid,
  input  logic [1:0]          cmd_mode,
  input  logic                cmp12,
  input  logic                smp_valid,
  input  logic                smp_right,
  input  logic [SAMPLE_W-1:0] smp_data,
  output logic                busy,
  output logic                connect_done
);
  localparam int DEPTH = 2 * PAIRS;
  localparam int CW    = $clog2(PAIRS + 1);

  logic [1:0] rst_pipe;
  logic       rst_sn;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sn = rst_pipe[1];

  logic ref_shift, win_shift, all_match;
  logic [CW-1:0] match_count;
  logic [DEPTH*SAMPLE_W-1:0] ref_q, ref_nx, win_q, win_nx;

  cc_sample_shift #(.W(SAMPLE_W), .DEPTH(DEPTH)) u_ref (
    .clk(clk), .rst_n(rst_sn), .shift_en(ref_shift), .din(smp_data),
    .dout(ref_q), .dout_next(ref_nx));

  cc_sample_shift #(.W(SAMPLE_W), .DEPTH(DEPTH)) u_win (
    .clk(clk), .rst_n(rst_sn), .shift_en(win_shift), .din(smp_data),
    .dout(win_q), .dout_next(win_nx));

  cc_pair_compare #(.W(SAMPLE_W), .PAIRS(PAIRS), .LOW_BITS(LOW_BITS)) u_cmp (
    .ref_flat(ref_q), .win_flat(win_nx), .mask_en(cmp12),
    .match_count(match_count), .all_match(all_match));

  cc_seq_ctrl #(.PAIRS(PAIRS), .PREP_CYCLES(PREP_CYCLES), .DIRECT_WORDS(DIRECT_WORDS)) u_ctrl (
    .clk(clk), .rst_n(rst_sn), .cmd_valid(cmd_valid), .cmd_mode(cmd_mode),
    .smp_valid(smp_valid), .smp_right(smp_right), .match_count(match_count),
    .all_match(all_match), .ref_shift(ref_shift), .win_shift(win_shift),
    .busy(busy), .done(connect_done));

  // the reference snapshot and the window state are observed only through the comparator
  logic unused_nx;
  assign unused_nx = ^{ref_nx, win_q};
endmodule

// File: tb/cc_connect_matcher_test.sv
`timescale 1ns/1ps
module cc_connect_matcher_test;
  logic clk = 1'b0;
  logic rst_n, cmd_valid, cmp12, smp_valid, smp_right;
  logic [1:0]  cmd_mode;
  logic [15:0] smp_data;
  logic busy, connect_done;
  int checks = 0, fails = 0, done_seen = 0;

  always #2.5 clk = ~clk;

  cc_connect_matcher uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_mode(cmd_mode),
    .cmp12(cmp12), .smp_valid(smp_valid), .smp_right(smp_right),
    .smp_data(smp_data), .busy(busy), .connect_done(connect_done));

  typedef struct packed {
    logic [1:0]       mode;
    logic             mask;
    logic             exp;
    logic [5:0][15:0] flip;   // {s5,s4,s3,s2,s1,s0}
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VEC [NV] = '{
    '{2'b11, 1'b0, 1'b1, {16'h0000,16'h0000,16'h0000,16'h0000,16'h0000,16'h0000}},
    '{2'b11, 1'b0, 1'b0, {16'h0000,16'h0000,16'h0010,16'h0000,16'h0000,16'h0000}},
    '{2'b11, 1'b1, 1'b1, {16'h0004,16'h0000,16'h0000,16'h0000,16'h0000,16'h000F}},
    '{2'b11, 1'b1, 1'b0, {16'h0000,16'h0000,16'h0000,16'h0100,16'h0000,16'h0000}},
    '{2'b10, 1'b0, 1'b1, {16'h0000,16'h0000,16'h0000,16'h0000,16'h0010,16'h0000}},
    '{2'b10, 1'b0, 1'b0, {16'h0000,16'h0010,16'h0000,16'h0000,16'h0010,16'h0000}},
    '{2'b10, 1'b1, 1'b1, {16'h0000,16'h0000,16'h0000,16'h0020,16'h0000,16'h0002}},
    '{2'b01, 1'b0, 1'b1, {16'hFFFF,16'hFFFF,16'hFFFF,16'hFFFF,16'hFFFF,16'hFFFF}},
    '{2'b10, 1'b0, 1'b1, {16'h0000,16'h0000,16'h0000,16'h0000,16'h0000,16'h0000}}
  };

  function automatic logic [15:0] refv(int k);
    return 16'hA5A0 + 16'(k) * 16'h0111;
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick_sample(logic right, logic [15:0] d);
    @(negedge clk); smp_valid = 1'b1; smp_right = right; smp_data = d;
    @(negedge clk); smp_valid = 1'b0;
    if (connect_done) done_seen++;
  endtask

  task automatic command(logic [1:0] m);
    @(negedge clk); cmd_valid = 1'b1; cmd_mode = m;
    @(negedge clk); cmd_valid = 1'b0;
    if (connect_done) done_seen++;
  endtask

  task automatic load_ref();
    for (int k = 0; k < 6; k++) tick_sample(k[0], refv(k));
  endtask

  task automatic send_match(int upto);
    for (int k = 0; k < upto; k++) tick_sample(k[0], refv(k));
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: got 1 expected 0");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_mode = 2'b00; cmp12 = 1'b0;
    smp_valid = 1'b0; smp_right = 1'b0; smp_data = '0;
    repeat (4) @(negedge clk);
    chk("R1 busy in reset", int'(busy), 0);
    chk("R1 done in reset", int'(connect_done), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("R1 busy after reset", int'(busy), 0);

    // R4: two older idle samples are pushed out by six newer ones
    tick_sample(1'b0, 16'h1111); tick_sample(1'b1, 16'h2222);
    load_ref();
    // R3: a stop while idle changes nothing
    done_seen = 0;
    command(2'b00);
    chk("R3 busy after idle stop", int'(busy), 0);
    chk("R3 no pulse on idle stop", done_seen, 0);

    // R5: first start, samples inside the preparation interval are ignored
    command(2'b11);
    chk("R2 busy after start", int'(busy), 1);
    send_match(6);
    chk("R5 no connect during preparation", done_seen, 0);
    repeat (1000) @(negedge clk);
    tick_sample(1'b1, refv(1));   // stray right sample, skipped
    send_match(5);
    chk("R7 no connect before sixth word", done_seen, 0);
    tick_sample(1'b1, refv(5));
    chk("R4 R7 connect on last six reference samples", done_seen, 1);
    chk("R7 busy cleared at connect", int'(busy), 0);
    @(negedge clk);
    chk("R11 pulse lasts one cycle", int'(connect_done), 0);

    // table of search cases
    for (int v = 0; v < NV; v++) begin
      load_ref();
      @(negedge clk); cmp12 = VEC[v].mask;
      command(VEC[v].mode);
      done_seen = 0;
      for (int k = 0; k < 6; k++) tick_sample(k[0], refv(k) ^ VEC[v].flip[k]);
      chk($sformatf("R7 R8 R9 R10 row %0d connect", v), int'(done_seen != 0), int'(VEC[v].exp));
      if (!VEC[v].exp) begin
        chk($sformatf("R2 row %0d still busy", v), int'(busy), 1);
        command(2'b00);
      end
      chk($sformatf("R2 row %0d idle at end", v), int'(busy), 0);
    end
    @(negedge clk); cmp12 = 1'b0;

    // R6: restart mid-search, no preparation, waits for a left sample
    load_ref();
    command(2'b11);
    tick_sample(1'b0, ~refv(0)); tick_sample(1'b1, ~refv(1));
    command(2'b11);
    done_seen = 0;
    tick_sample(1'b1, refv(1));
    send_match(6);
    chk("R6 restart connects without preparation", done_seen, 1);

    // R2: stop during an active search
    load_ref();
    command(2'b10);
    tick_sample(1'b0, refv(0)); tick_sample(1'b1, refv(1));
    done_seen = 0;
    command(2'b00);
    chk("R2 stop clears busy", int'(busy), 0);
    chk("R2 stop gives no pulse", done_seen, 0);

    // R10: mask turned on in the middle of a search
    load_ref();
    command(2'b11);
    done_seen = 0;
    tick_sample(1'b0, refv(0) ^ 16'h0003);
    for (int k = 1; k < 4; k++) tick_sample(k[0], refv(k));
    @(negedge clk); cmp12 = 1'b1;
    tick_sample(1'b0, refv(4)); tick_sample(1'b1, refv(5));
    chk("R10 mask switched on mid-search", done_seen, 1);
    @(negedge clk); cmp12 = 1'b0;

    finish_run();
  end
endmodule